// File: doc/BRIEF.md
# Set/Clear Inter-Core Mailbox Bank

This block keeps a bank of 32-bit message words that cores use to signal each other. Each core owns four words, so there are sixteen in total with the default parameters. Word number k, where k = core*4 + slot, belongs to that core and slot.

Software never stores a whole word directly. A word-wide register port exposes two address windows. A write to the upper-middle window merges its data into the chosen word with a bitwise OR. A write to the top window removes the bits that are 1 in its data. The top window is also the only place where a word can be read back.

A pending flag for every word is high while that word holds any 1 bit. These flags feed an interrupt router, which lies outside this block.

Top module: `mbx_bank`

## Requirements
- R1: While reset is asserted and after it is released, every word is zero, every pending flag is low and the read data is zero.
- R2: A write whose address bits [7:6] are 2'b10 ORs the write data into word k = address bits [5:2]. No other word changes.
- R3: A write whose address bits [7:6] are 2'b11 clears, in word k = address bits [5:2], each bit that is 1 in the write data. No other word changes.
- R4: A read whose address bits [7:6] are 2'b11 places word k on the read data output in the cycle after the access. The output then holds that value until the next read.
- R5: A read with address bits [7:6] other than 2'b11 returns zero. This covers both the set window and offsets below 0x80.
- R6: The pending flag of word k is high exactly when word k is nonzero. It follows a write from the clock edge that performs that write.
- R7: A write to an offset below 0x80 changes no word.
- R8: Address bits [1:0] are ignored. Every access is a full 32-bit word.
- R9: A read never changes any word.
- R10: While the access-valid input is low, no word changes, even if the write and data inputs are active.
- R11: Pending bit k corresponds to word k, and word k serves core k/4, slot k%4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data (set mask or clear mask) |
| bus_rdata | output | 32 | Registered read data |
| pending | output | 16 | Nonzero flag per word |

## Verification
The hardest case is showing that an access leaves the other fifteen words untouched. A wrong index, or a window decode that leaks into the other window, only shows up when neighbouring words already hold distinct nonzero patterns. The stimulus therefore first fills every word with a unique value. It then issues targeted sets, clears, misaligned offsets, low-offset writes and writes with the strobe low. After each of these it sweeps all sixteen words through the read window and compares the full pending vector against a model kept in the bench.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } mbx_win_e;

  // Two top address bits choose the window: 2'b10 merge, 2'b11 clear/read.
  function automatic mbx_win_e win_decode(input logic [1:0] sel);
    case (sel)
      2'b10:   win_decode = WIN_SET;
      2'b11:   win_decode = WIN_CLR;
      default: win_decode = WIN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 16,
  parameter int IDX_W   = $clog2(NUM_MBX),
  parameter int ADDR_W  = IDX_W + 4
) (
  input  logic               valid,
  input  logic               write,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_MBX-1:0] set_hit,
  output logic [NUM_MBX-1:0] clr_hit,
  output logic               rd_any,
  output logic               rd_sel,
  output logic [IDX_W-1:0]   rd_idx
);

  mbx_win_e   win;
  logic [IDX_W-1:0] idx;
  logic [1:0] unused_lsb;

  assign unused_lsb = addr[1:0];
  assign win        = win_decode(addr[ADDR_W-1 -: 2]);
  assign idx        = addr[2 +: IDX_W];

  always_comb begin
    set_hit = '0;
    clr_hit = '0;
    if (valid && write && win == WIN_SET) set_hit = NUM_MBX'(1) << idx;
    if (valid && write && win == WIN_CLR) clr_hit = NUM_MBX'(1) << idx;
  end

  assign rd_any = valid && !write;
  assign rd_sel = rd_any && (win == WIN_CLR);
  assign rd_idx = idx;

endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              pend
);

  // Merge rule: clear first, then set, so a set wins on a shared bit.
  function automatic logic [DATA_W-1:0] word_next(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] set_m,
    input logic [DATA_W-1:0] clr_m
  );
    word_next = (cur & ~clr_m) | set_m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (set_en || clr_en) begin
      q <= word_next(q, set_en ? wdata : '0, clr_en ? wdata : '0);
    end
  end

  assign pend = |q;

endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport #(
  parameter int NUM_MBX = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_any,
  input  logic                      rd_sel,
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic [NUM_MBX*DATA_W-1:0] words,
  output logic [DATA_W-1:0]         rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_any) begin
      rdata <= rd_sel ? words[rd_idx*DATA_W +: DATA_W] : '0;
    end
  end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int NUM_CORES = 4,
  parameter int SLOTS     = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_MBX   = NUM_CORES * SLOTS,
  parameter int IDX_W     = $clog2(NUM_MBX),
  parameter int ADDR_W    = IDX_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_MBX-1:0] pending
);

  logic [NUM_MBX-1:0]        set_hit;
  logic [NUM_MBX-1:0]        clr_hit;
  logic                      rd_any;
  logic                      rd_sel;
  logic [IDX_W-1:0]          rd_idx;
  logic [NUM_MBX*DATA_W-1:0] words;

  mbx_decode #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .valid   (bus_valid),
    .write   (bus_write),
    .addr    (bus_addr),
    .set_hit (set_hit),
    .clr_hit (clr_hit),
    .rd_any  (rd_any),
    .rd_sel  (rd_sel),
    .rd_idx  (rd_idx)
  );

  for (genvar k = 0; k < NUM_MBX; k++) begin : g_word
    mbx_word #(.DATA_W(DATA_W)) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_hit[k]),
      .clr_en (clr_hit[k]),
      .wdata  (bus_wdata),
      .q      (words[k*DATA_W +: DATA_W]),
      .pend   (pending[k])
    );
  end

  mbx_rdport #(.NUM_MBX(NUM_MBX), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_any (rd_any),
    .rd_sel (rd_sel),
    .rd_idx (rd_idx),
    .words  (words),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
  parameter int NUM_MBX = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_MBX-1:0] pending,
  input logic [NUM_MBX-1:0] set_hit,
  input logic [NUM_MBX-1:0] clr_hit
);

  assert_reset_clean_R1: assert property (@(posedge clk)
    !rst_n |=> (pending == '0 && bus_rdata == '0));

  assert_set_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_hit));

  assert_clr_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_hit) && ((set_hit & clr_hit) == '0));

  assert_pend_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(set_hit)) == '0));

  assert_pend_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pending) & ~pending & ~$past(clr_hit)) == '0));

  assert_rd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[ADDR_W-1 -: 2] != 2'b11) |=> (bus_rdata == '0));

  assert_rd_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> $stable(pending));

  assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> $stable(pending));

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind mbx_bank mbx_bank_chk #(.NUM_MBX(NUM_MBX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pending   (pending),
  .set_hit   (set_hit),
  .clr_hit   (clr_hit)
);

// File: tb/tb_mbx_bank.sv
module tb_mbx_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pending;

  int vectors = 0;
  int fails   = 0;
  logic [31:0] exp_mb [16];

  always #2 clk = ~clk;

  mbx_bank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pending   (pending)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model of the write rules (R2, R3, R7, R8): bits [7:6] pick the window, [5:2] the word.
  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a[7:6] == 2'b10) exp_mb[a[5:2]] = exp_mb[a[5:2]] | d;
    else if (a[7:6] == 2'b11) exp_mb[a[5:2]] = exp_mb[a[5:2]] & ~d;
  endtask

  function automatic logic [15:0] exp_pend();
    logic [15:0] p;
    for (int k = 0; k < 16; k++) p[k] = (exp_mb[k] != 0);
    return p;
  endfunction

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_word(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic sweep(input string req);
    logic [31:0] v;
    check(pending == exp_pend(), {req, " R6 pending"}, 32'(pending), 32'(exp_pend()));
    for (int k = 0; k < 16; k++) begin
      rd_word(8'hC0 + 8'(4 * k), v);
      check(v == exp_mb[k], {req, " R4 word"}, v, exp_mb[k]);
    end
  endtask

  task automatic t_reset();
    check(pending == 16'h0, "R1 pending", 32'(pending), 32'h0);
    check(bus_rdata == 32'h0, "R1 rdata", bus_rdata, 32'h0);
    sweep("R1");
  endtask

  task automatic t_mapping();
    // R11: core 2 slot 1 is word 9
    wr_word(8'h80 + 8'(4 * (2 * 4 + 1)), 32'h0000_0100);
    check(pending == 16'h0200, "R11 mapping", 32'(pending), 32'h200);
    wr_word(8'hC0 + 8'(4 * 9), 32'hFFFF_FFFF);
    check(pending == 16'h0, "R6 clear to zero", 32'(pending), 32'h0);
  endtask

  task automatic t_fill_or();
    for (int k = 0; k < 16; k++) wr_word(8'h80 + 8'(4 * k), 32'h1111_0000 * (k + 1) + 32'(k));
    sweep("R2 fill");
    wr_word(8'h80 + 8'd20, 32'h8000_0001);
    sweep("R2 OR merge");
  endtask

  task automatic t_clear();
    wr_word(8'hC0 + 8'd20, 32'h0000_FFFF);
    sweep("R3 partial");
    wr_word(8'hC0 + 8'd60, 32'hFFFF_FFFF);
    check(pending[15] == 1'b0, "R3 R6 full clear", 32'(pending), 32'(exp_pend()));
    sweep("R3 full");
  endtask

  task automatic t_nonclear_reads();
    logic [31:0] v;
    rd_word(8'h84, v);
    check(v == 32'h0, "R5 set window read", v, 32'h0);
    rd_word(8'h10, v);
    check(v == 32'h0, "R5 low read", v, 32'h0);
  endtask

  task automatic t_low_ignored();
    for (int a = 0; a < 8'h80; a += 12) wr_word(8'(a), 32'hFFFF_FFFF);
    sweep("R7");
  endtask

  task automatic t_misaligned();
    wr_word(8'h80 + 8'd12 + 8'd3, 32'h0F00_0000);
    wr_word(8'hC0 + 8'd4 + 8'd1, 32'h0000_00FF);
    sweep("R8");
  endtask

  task automatic t_read_keeps();
    logic [31:0] a, b;
    rd_word(8'hC8, a);
    rd_word(8'hC8, b);
    check(a == b && b == exp_mb[2], "R9 read twice", b, exp_mb[2]);
    check(pending == exp_pend(), "R9 pending", 32'(pending), 32'(exp_pend()));
  endtask

  task automatic t_valid_low();
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 8'hC0; bus_wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    bus_addr = 8'h88;
    repeat (2) @(negedge clk);
    bus_write = 1'b0;
    sweep("R10");
  endtask

  task automatic t_rdata_hold();
    logic [31:0] v;
    rd_word(8'hCC, v);
    wr_word(8'h80 + 8'd12, 32'h0000_0070);
    repeat (3) @(negedge clk);
    check(bus_rdata == v, "R4 hold", bus_rdata, v);
    rd_word(8'hCC, v);
    check(v == exp_mb[3], "R4 new value", v, exp_mb[3]);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) exp_mb[k] = '0;
    repeat (3) @(negedge clk);
    check(pending == 16'h0 && bus_rdata == 32'h0, "R1 in reset", 32'(pending), 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_mapping();
    t_fill_or();
    t_clear();
    t_nonclear_reads();
    t_low_ignored();
    t_misaligned();
    t_read_keeps();
    t_valid_low();
    t_rdata_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule